// File: doc/BRIEF.md
# Serial Volume Control Register Interface

This block is the digital front end of a multichannel volume controller. A host sends 8-bit control bytes over four pins: a serial clock, a serial data line, an active-low write enable and an active-low load strobe. The block decodes each byte either as a target selection or as a level setting. It keeps one 7-bit master attenuation value and six 5-bit channel gain values. Each value has a shadow copy, which the serial stream writes, and an active copy, which drives the outputs.

All four serial pins are sampled by a faster system clock. Each pin passes through a two-flop synchronizer, and its edges are detected in the system clock domain. Bits enter MSB first and are taken on the falling edge of the serial clock, so a serial clock that idles high and one that idles low both work. A byte with bit 7 set is an address byte. A byte with bit 7 clear is a level byte for the current target, so one address byte can be followed by a run of level bytes.

In four-wire mode the active set copies the shadow set while the load strobe is low. In three-wire mode (`auto_load_i` = 1) the host ties load to write. The load pin is then ignored, and the copy happens once, when write enable is released. After reset every output reads zero and the mute flag is set. The mute flag clears on the first load.

The byte receiver is a three-state machine:
- ST_IDLE: write enable is high.
- ST_SHIFT: bits are being collected.
- ST_DONE: a one-cycle state that presents the completed byte.

Its transitions are:
- IDLE→SHIFT when write enable goes low.
- SHIFT→IDLE when write enable goes high.
- SHIFT→DONE on the eighth falling serial clock edge.
- DONE→SHIFT when write enable is still low.
- DONE→IDLE when write enable is high.

Top module: `volctl_serial_if`

## Requirements
- R1: Bytes are shifted in MSB first, bit 7 down to bit 0, one bit per falling edge of `sclk_i`, with eight edges making one byte.
- R2: A serial clock that idles low and one that idles high both deliver the same bytes.
- R3: While `wr_n_i` is high, serial clock edges and data are ignored, and no shadow or active value changes.
- R4: An address byte (bit 7 = 1) selects its target from bits 2:0: code 0 is the master, codes 1 to 6 are channels 1 to 6, and code 7 selects nothing. Level bytes sent while nothing is selected change no value. After reset nothing is selected.
- R5: A level byte (bit 7 = 0) writes bits 6:0 to the master shadow, or bits 4:0 to the selected channel shadow. The selection persists across level bytes and write frames until the next address byte.
- R6: A byte cut short by `wr_n_i` rising before its eighth edge is discarded, and the next frame starts at bit 7.
- R7: In four-wire mode (`auto_load_i` = 0), the active outputs copy the shadow values while `ld_n_i` is low. They do not change at any other time.
- R8: In three-wire mode (`auto_load_i` = 1), one copy occurs when `wr_n_i` rises, and `ld_n_i` has no effect.
- R9: After reset all active values are 0 and `mute_o` is 1. `mute_o` clears on the first load and stays clear until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| sdat_i | input | 1 | Serial data, MSB first |
| wr_n_i | input | 1 | Active-low write enable (chip select) |
| ld_n_i | input | 1 | Active-low load strobe |
| auto_load_i | input | 1 | 1 = three-wire mode with automatic load on write release |
| master_att_o | output | 7 | Active master attenuation value |
| chan_gain_o | output | 30 | Active channel gains; channel n sits at bits 5n-1:5n-5 |
| mute_o | output | 1 | High from reset until the first load |

## Verification
The assertions check four things on every cycle:
- The active values hold unless a load is in progress, and a load copies the shadow values of the previous cycle.
- The selection changes only on an address byte.
- A level byte changes no shadow value while nothing is selected.
- The mute flag clears on a load and never sets again.

Only the bench's scenarios can show the following:
- Bit order is correct under both serial clock polarities.
- Edges sent while write enable is high leave nothing behind.
- A truncated byte does not shift the alignment of the next frame.
- In three-wire mode a low load pin alone has no effect.

// File: rtl/volctl_pkg.sv
package volctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } rx_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/volctl_sync.sv
module volctl_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/volctl_rx.sv
module volctl_rx
    import volctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic              sclk_fall,
    input  logic              sdat,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sreg_q;
    logic              last_bit;

    assign last_bit = sclk_fall && (cnt_q == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_act) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!wr_act)       state_d = ST_IDLE;
                else if (last_bit) state_d = ST_DONE;
            end
            ST_DONE:  state_d = wr_act ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sreg_q <= '0;
        end else if (state_q == ST_SHIFT && wr_act) begin
            if (sclk_fall) begin
                sreg_q <= {sreg_q[BYTE_W-2:0], sdat};
                cnt_q  <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign byte_vld = (state_q == ST_DONE);
    assign byte_q   = sreg_q;
endmodule

// File: rtl/volctl_regs.sv
module volctl_regs
    import volctl_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int MASTER_W = 7,
    parameter int CHAN_W   = 5,
    parameter int ADDR_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_q,
    input  logic                     load,
    output logic [ADDR_W-1:0]        sel_o,
    output logic [MASTER_W-1:0]      shadow_m_o,
    output logic [NUM_CH*CHAN_W-1:0] shadow_c_o,
    output logic [MASTER_W-1:0]      master_o,
    output logic [NUM_CH*CHAN_W-1:0] chan_o,
    output logic                     mute_o
);
    localparam logic [ADDR_W-1:0] SEL_NONE = {ADDR_W{1'b1}};

    logic is_addr, is_level;
    logic [ADDR_W-1:0] sel_q;
    logic [MASTER_W-1:0] shm_q, actm_q;
    logic mute_q;

    assign is_addr  = byte_vld &  byte_q[BYTE_W-1];
    assign is_level = byte_vld & ~byte_q[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_NONE;
            shm_q  <= '0;
            actm_q <= '0;
            mute_q <= 1'b1;
        end else begin
            if (is_addr) sel_q <= byte_q[ADDR_W-1:0];
            if (is_level && sel_q == '0) shm_q <= byte_q[MASTER_W-1:0];
            if (load) begin
                actm_q <= shm_q;
                mute_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CHAN_W-1:0] sh_q, act_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q  <= '0;
                act_q <= '0;
            end else begin
                if (is_level && sel_q == ADDR_W'(g + 1)) sh_q <= byte_q[CHAN_W-1:0];
                if (load) act_q <= sh_q;
            end
        end
        assign shadow_c_o[g*CHAN_W +: CHAN_W] = sh_q;
        assign chan_o[g*CHAN_W +: CHAN_W]     = act_q;
    end

    assign sel_o      = sel_q;
    assign shadow_m_o = shm_q;
    assign master_o   = actm_q;
    assign mute_o     = mute_q;
endmodule

// File: rtl/volctl_serial_if.sv
module volctl_serial_if
    import volctl_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int MASTER_W = 7,
    parameter int CHAN_W   = 5,
    parameter int ADDR_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sdat_i,
    input  logic                     wr_n_i,
    input  logic                     ld_n_i,
    input  logic                     auto_load_i,
    output logic [MASTER_W-1:0]      master_att_o,
    output logic [NUM_CH*CHAN_W-1:0] chan_gain_o,
    output logic                     mute_o
);
    // bit order of the synchronized bus: {ld_n, wr_n, sdat, sclk}
    logic [3:0] pins_s, pins_r, pins_f;
    logic       byte_vld;
    logic [BYTE_W-1:0] byte_q;
    logic       load_pulse;
    logic [ADDR_W-1:0] sel;
    logic [MASTER_W-1:0] shadow_m;
    logic [NUM_CH*CHAN_W-1:0] shadow_c;

    volctl_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ld_n_i, wr_n_i, sdat_i, sclk_i}),
        .sync_o  (pins_s),
        .rise_o  (pins_r),
        .fall_o  (pins_f)
    );

    volctl_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_act    (~pins_s[2]),
        .sclk_fall (pins_f[0]),
        .sdat      (pins_s[1]),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q)
    );

    assign load_pulse = auto_load_i ? pins_r[2] : ~pins_s[3];

    volctl_regs #(
        .NUM_CH(NUM_CH), .MASTER_W(MASTER_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_q     (byte_q),
        .load       (load_pulse),
        .sel_o      (sel),
        .shadow_m_o (shadow_m),
        .shadow_c_o (shadow_c),
        .master_o   (master_att_o),
        .chan_o     (chan_gain_o),
        .mute_o     (mute_o)
    );
endmodule

// File: rtl/volctl_serial_if_chk.sv
module volctl_serial_if_chk #(
    parameter int NUM_CH   = 6,
    parameter int MASTER_W = 7,
    parameter int CHAN_W   = 5,
    parameter int ADDR_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_pulse,
    input logic                     byte_vld,
    input logic [7:0]               byte_q,
    input logic [ADDR_W-1:0]        sel,
    input logic [MASTER_W-1:0]      shadow_m,
    input logic [NUM_CH*CHAN_W-1:0] shadow_c,
    input logic [MASTER_W-1:0]      master_att_o,
    input logic [NUM_CH*CHAN_W-1:0] chan_gain_o,
    input logic                     mute_o
);
    localparam logic [ADDR_W-1:0] SEL_NONE = {ADDR_W{1'b1}};

    p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> ($stable(master_att_o) && $stable(chan_gain_o)));

    p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (master_att_o == $past(shadow_m) && chan_gain_o == $past(shadow_c)));

    p_mute_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !mute_o);

    p_mute_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_o |=> !mute_o);

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && byte_q[7]) |=> $stable(sel));

    p_none_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_q[7] && sel == SEL_NONE) |=> ($stable(shadow_m) && $stable(shadow_c)));
endmodule

bind volctl_serial_if volctl_serial_if_chk #(
    .NUM_CH(NUM_CH), .MASTER_W(MASTER_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_pulse   (load_pulse),
    .byte_vld     (byte_vld),
    .byte_q       (byte_q),
    .sel          (sel),
    .shadow_m     (shadow_m),
    .shadow_c     (shadow_c),
    .master_att_o (master_att_o),
    .chan_gain_o  (chan_gain_o),
    .mute_o       (mute_o)
);

// File: tb/volctl_serial_if_tb.sv
module volctl_serial_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, wr_n = 1'b1, ld_n = 1'b1, auto_ld = 1'b0;
    logic idle_high = 1'b0;
    logic [6:0]  master;
    logic [29:0] chans;
    logic        mute;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    volctl_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .wr_n_i(wr_n),
        .ld_n_i(ld_n), .auto_load_i(auto_ld), .master_att_o(master),
        .chan_gain_o(chans), .mute_o(mute)
    );

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int ch(int n);
        return int'(chans[(n-1)*5 +: 5]);
    endfunction

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sdat = b[i];
            if (idle_high) begin
                wait_clk(HALF); sclk = 1'b0;
                wait_clk(HALF); sclk = 1'b1;
            end else begin
                sclk = 1'b1; wait_clk(HALF);
                sclk = 1'b0; wait_clk(HALF);
            end
        end
    endtask

    task automatic begin_frame();
        sclk = idle_high; wait_clk(HALF);
        wr_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic end_frame();
        wait_clk(HALF); wr_n = 1'b1; wait_clk(10);
    endtask

    task automatic frame2(logic [7:0] a, logic [7:0] b);
        begin_frame(); send_bits(a, 8); send_bits(b, 8); end_frame();
    endtask

    task automatic do_load();
        ld_n = 1'b0; wait_clk(8); ld_n = 1'b1; wait_clk(6);
    endtask

    task automatic t_reset();
        chk("R9 reset mute", int'(mute), 1);
        chk("R9 reset master", int'(master), 0);
        chk("R9 reset chans", int'(chans == '0), 1);
    endtask

    task automatic t_idle_low_master();
        idle_high = 1'b0;
        frame2(8'h80, 8'h2A);
        chk("R7 no copy before load", int'(master), 0);
        chk("R9 mute before load", int'(mute), 1);
        do_load();
        chk("R1 master msb-first", int'(master), 'h2A);
        chk("R9 mute cleared", int'(mute), 0);
    endtask

    task automatic t_idle_high_stream();
        idle_high = 1'b1;
        begin_frame();
        send_bits(8'h83, 8); send_bits(8'h11, 8); send_bits(8'h1F, 8);
        end_frame();
        do_load();
        chk("R2 idle-high ch3 last level", ch(3), 'h1F);
        chk("R2 idle-high master kept", int'(master), 'h2A);
        idle_high = 1'b0;
        frame2(8'h0C, 8'h0D);
        do_load();
        chk("R5 selection persists over frames", ch(3), 'h0D);
    endtask

    task automatic t_write_high();
        logic [6:0]  m0;
        logic [29:0] c0;
        m0 = master; c0 = chans;
        for (int i = 0; i < 16; i++) begin
            sdat = i[0]; sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
        end
        do_load();
        chk("R3 edges with write high ignored (master)", int'(master), int'(m0));
        chk("R3 edges with write high ignored (chans)", int'(chans == c0), 1);
        begin_frame(); send_bits(8'h07, 8); end_frame(); do_load();
        chk("R3 next frame aligned", ch(3), 'h07);
    endtask

    task automatic t_addressing();
        logic [29:0] c0;
        logic [6:0]  m0;
        c0 = chans; m0 = master;
        frame2(8'h87, 8'h0C);
        do_load();
        chk("R4 code 7 ignores level (chans)", int'(chans == c0), 1);
        chk("R4 code 7 ignores level (master)", int'(master), int'(m0));
        frame2(8'h86, 8'h09);
        frame2(8'h81, 8'h7E);
        do_load();
        chk("R4 channel 6 selected", ch(6), 'h09);
        chk("R5 channel takes low 5 bits", ch(1), 'h1E);
        frame2(8'h80, 8'h7F);
        do_load();
        chk("R5 master takes low 7 bits", int'(master), 'h7F);
        chk("R4 other channels untouched", ch(2), 0);
    endtask

    task automatic t_partial();
        begin_frame(); send_bits(8'hFF, 4); end_frame();
        begin_frame(); send_bits(8'h33, 8); end_frame();
        do_load();
        chk("R6 partial byte discarded", int'(master), 'h33);
    endtask

    task automatic t_three_wire();
        auto_ld = 1'b1;
        begin_frame(); send_bits(8'h82, 8); send_bits(8'h05, 8);
        wait_clk(HALF);
        chk("R8 no copy while write low", ch(2), 0);
        ld_n = 1'b0; wait_clk(8); ld_n = 1'b1; wait_clk(4);
        chk("R8 load pin ignored", ch(2), 0);
        wr_n = 1'b1; wait_clk(10);
        chk("R8 auto load on write release", ch(2), 'h05);
        chk("R9 mute stays clear", int'(mute), 0);
        auto_ld = 1'b0;
    endtask

    initial begin
        wait_clk(4); rst_n = 1'b1; wait_clk(4);
        t_reset();
        t_idle_low_master();
        t_idle_high_stream();
        t_write_high();
        t_addressing();
        t_partial();
        t_three_wire();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog (all R) actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule